// File: doc/BRIEF.md
# Complementary Dead-Time Gate Pair

This block turns one raw pulse-width-modulated level into two gate drives, A and B, for the upper and lower switches of a half bridge. It inserts a guard interval at each switching transition so that one switch is off before the other turns on. Drive A follows the raw level, but it rises only after the level has stayed high long enough. Drive B follows the inverted level, but it rises only after the level has stayed low long enough. Both drives are active high.

The turn-on delay of A and the turn-on delay of B are two separate 14-bit counts of clock cycles, each from 0 to 16383. A common setting is 15 cycles for both. Each drive has its own enable for delay insertion. With its enable low, a drive copies the raw level (A) or its inverse (B) with no guard interval.

Each drive is produced by its own three-state machine:

- LOW: the drive is off.
- QUAL: the drive is off while the qualifying level is being counted.
- HIGH: the drive is on.

The transitions are:

- *arm*: LOW to QUAL, when the qualifying level is seen and the delay is non-zero.
- *pass*: LOW to HIGH, when the qualifying level is seen and the delay is zero.
- *abort*: QUAL to LOW, when the level drops before the count completes.
- *fire*: QUAL to HIGH, when the count reaches the delay.
- *release*: HIGH to LOW, when the level drops.
- *follow*: with the enable low, the machine copies the sampled level straight into LOW or HIGH.

Every output is the decode of a registered state, so each output responds one clock after the raw level is sampled.

Top module: `comp_deadtime`

## Requirements
- R1: While `rst_n` is low, `gate_a` and `gate_b` are both 0.
- R2: With `dly_en_a`=1, `gate_a` is 1 in the cycle after the edge at which `pwm_in` has been sampled high at `rise_dly`+1 consecutive edges, and it stays 1 while `pwm_in` stays high.
- R3: `gate_a` is 0 in the cycle after any edge at which `pwm_in` is sampled low.
- R4: With `dly_en_a`=1 and `rise_dly`=N>0, a high pulse of N or fewer sampled cycles produces no `gate_a` pulse, and a pulse of exactly N+1 samples produces a single-cycle `gate_a` pulse.
- R5: With `dly_en_b`=1, `gate_b` is 1 after `pwm_in` has been sampled low at `fall_dly`+1 consecutive edges, and it is 0 in the cycle after any edge at which `pwm_in` is sampled high.
- R6: `rise_dly` and `fall_dly` are independent 14-bit counts, and the largest value, 16383, is honoured exactly.
- R7: A delay of 0 adds nothing beyond the one-cycle register: the enabled drive equals the level sampled at the previous edge (`pwm_in` for A, its inverse for B).
- R8: With `dly_en_a`=0, `gate_a` equals `pwm_in` sampled at the previous edge. With `dly_en_b`=0, `gate_b` equals the inverse of that sample.
- R9: `gate_a` and `gate_b` are never 1 in the same cycle, in any combination of enables and delays.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counting is in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Raw modulated level |
| rise_dly | input | 14 | Turn-on delay of drive A, in cycles |
| fall_dly | input | 14 | Turn-on delay of drive B, in cycles |
| dly_en_a | input | 1 | 1 inserts the delay on A; 0 makes A follow the raw level |
| dly_en_b | input | 1 | 1 inserts the delay on B; 0 makes B follow the inverted level |
| gate_a | output | 1 | Upper gate drive, active high |
| gate_b | output | 1 | Lower gate drive, active high |

## Verification
Two situations are hard to reach from the ports.

- **Counter limit.** A turn-on delay of 16383 shows its true length only if the raw level is held unbroken for more than sixteen thousand cycles. The bench therefore holds `pwm_in` high for that long and checks that A rises on the exact cycle.
- **Abort edge.** A pulse that falls one sample short of the delay must be told apart from one that just reaches it. The bench drives pulses of exactly N and N+1 samples.

Delays and enables are changed only while the affected drive is settled off. That way each run starts from the LOW state, and a simple run-length model of the raw level gives the expected value in every cycle.

// File: rtl/comp_deadtime_pkg.sv
package comp_deadtime_pkg;

    // Width of each programmable delay count.
    localparam int DT_DLY_W = 14;

    // Per-drive state.
    typedef enum logic [1:0] {
        DT_LOW  = 2'd0,
        DT_QUAL = 2'd1,
        DT_HIGH = 2'd2
    } dt_state_e;

endpackage

// File: rtl/dt_rise_qual.sv
module dt_rise_qual
    import comp_deadtime_pkg::*;
#(
    parameter int DLY_W = DT_DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic [DLY_W-1:0] dly,
    input  logic             en,
    output logic             drv
);

    dt_state_e        st_q, st_nxt;
    logic [DLY_W-1:0] cnt_q, cnt_nxt;

    // Next-state logic.
    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        if (!en) begin
            // follow: copy the sampled level with no guard interval
            st_nxt  = lvl ? DT_HIGH : DT_LOW;
            cnt_nxt = '0;
        end else begin
            unique case (st_q)
                DT_LOW: begin
                    if (lvl) begin
                        if (dly == '0) begin
                            st_nxt = DT_HIGH;              // pass
                        end else begin
                            st_nxt  = DT_QUAL;             // arm
                            cnt_nxt = DLY_W'(1);
                        end
                    end
                end
                DT_QUAL: begin
                    if (!lvl) begin
                        st_nxt = DT_LOW;                   // abort
                    end else if (cnt_q >= dly) begin
                        st_nxt = DT_HIGH;                  // fire
                    end else begin
                        cnt_nxt = cnt_q + DLY_W'(1);
                    end
                end
                DT_HIGH: begin
                    if (!lvl) begin
                        st_nxt = DT_LOW;                   // release
                    end
                end
                default: st_nxt = DT_LOW;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DT_LOW;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // Output decode.
    always_comb begin
        drv = (st_q == DT_HIGH);
    end

endmodule

// File: rtl/comp_deadtime.sv
module comp_deadtime
    import comp_deadtime_pkg::*;
#(
    parameter int DLY_W = DT_DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    input  logic             dly_en_a,
    input  logic             dly_en_b,
    output logic             gate_a,
    output logic             gate_b
);

    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0] lvl_c;
    logic [NUM_CH-1:0] en_c;
    logic [NUM_CH-1:0] drv_c;
    logic [DLY_W-1:0]  dly_c [NUM_CH];

    // Channel 0 qualifies the high level (drive A);
    // channel 1 qualifies the low level (drive B).
    assign lvl_c    = {~pwm_in, pwm_in};
    assign en_c     = {dly_en_b, dly_en_a};
    assign dly_c[0] = rise_dly;
    assign dly_c[1] = fall_dly;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dt_rise_qual #(
            .DLY_W(DLY_W)
        ) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (lvl_c[g]),
            .dly  (dly_c[g]),
            .en   (en_c[g]),
            .drv  (drv_c[g])
        );
    end

    assign gate_a = drv_c[0];
    assign gate_b = drv_c[1];

endmodule

// File: rtl/comp_deadtime_chk.sv
module comp_deadtime_chk #(
    parameter int DLY_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_in,
    input logic [DLY_W-1:0] rise_dly,
    input logic [DLY_W-1:0] fall_dly,
    input logic             dly_en_a,
    input logic             dly_en_b,
    input logic             gate_a,
    input logic             gate_b
);

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_a && gate_b)); // R9

    AST_A_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(pwm_in) |-> !gate_a); // R3

    AST_B_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(pwm_in) |-> !gate_b); // R5

    AST_A_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_a) && $past(rst_n, 2) && $past(dly_en_a) && ($past(rise_dly) != '0)
        |-> $past(pwm_in, 2)); // R4

    AST_ZERO_DLY_A: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dly_en_a) && ($past(rise_dly) == '0)
        |-> gate_a == $past(pwm_in)); // R7

    AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(dly_en_a) |-> gate_a == $past(pwm_in)); // R8

    AST_BYPASS_B: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(dly_en_b) |-> gate_b == !$past(pwm_in)); // R8

endmodule

bind comp_deadtime comp_deadtime_chk #(.DLY_W(DLY_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_in  (pwm_in),
    .rise_dly(rise_dly),
    .fall_dly(fall_dly),
    .dly_en_a(dly_en_a),
    .dly_en_b(dly_en_b),
    .gate_a  (gate_a),
    .gate_b  (gate_b)
);

// File: tb/comp_deadtime_test.sv
`timescale 1ns/1ps
module comp_deadtime_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_in = 1'b0;
    logic [13:0] rise_dly = 14'd15;
    logic [13:0] fall_dly = 14'd15;
    logic        dly_en_a = 1'b1;
    logic        dly_en_b = 1'b1;
    logic        gate_a;
    logic        gate_b;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    comp_deadtime uut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
        .rise_dly(rise_dly), .fall_dly(fall_dly),
        .dly_en_a(dly_en_a), .dly_en_b(dly_en_b),
        .gate_a(gate_a), .gate_b(gate_b)
    );

    // Expected drives, built from run lengths of the sampled level.
    int   hi_run = 0;
    int   lo_run = 0;
    logic exp_a  = 1'b0;
    logic exp_b  = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= 0; lo_run <= 0; exp_a <= 1'b0; exp_b <= 1'b0;
        end else begin
            int hn, ln;
            hn = pwm_in ? ((hi_run < 30000) ? hi_run + 1 : hi_run) : 0;
            ln = pwm_in ? 0 : ((lo_run < 30000) ? lo_run + 1 : lo_run);
            hi_run <= hn;
            lo_run <= ln;
            exp_a  <= dly_en_a ? (hn > int'(rise_dly)) : pwm_in;
            exp_b  <= dly_en_b ? (ln > int'(fall_dly)) : !pwm_in;
        end
    end

    task automatic check(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(string ta, string tb);
        @(negedge clk);
        check(ta, "gate_a", gate_a, exp_a);
        check(tb, "gate_b", gate_b, exp_b);
        check("R9", "overlap", gate_a && gate_b, 1'b0);
    endtask

    task automatic run(int n, string ta, string tb);
        for (int i = 0; i < n; i++) step(ta, tb);
    endtask

    // B's delay and enable change while the level is high (B settled off);
    // A's change while the level is low (A settled off).
    task automatic cfg(int r, int f, logic ea, logic eb);
        pwm_in = 1'b1; run(3, "R2", "R5");
        fall_dly = 14'(f); dly_en_b = eb; run(2, "R2", "R5");
        pwm_in = 1'b0; run(3, "R3", "R5");
        rise_dly = 14'(r); dly_en_a = ea; run(2, "R3", "R5");
    endtask

    task automatic t_reset();
        for (int i = 0; i < 6; i++) begin
            pwm_in = i[0];
            @(negedge clk);
            check("R1", "gate_a in reset", gate_a, 1'b0);
            check("R1", "gate_b in reset", gate_b, 1'b0);
        end
        pwm_in = 1'b0;
        rst_n = 1'b1;
        run(4, "R1", "R1");
    endtask

    task automatic t_nominal();
        cfg(15, 15, 1'b1, 1'b1);
        pwm_in = 1'b0; run(30, "R3", "R5");
        pwm_in = 1'b1; run(50, "R2", "R5");
        pwm_in = 1'b0; run(50, "R3", "R5");
        pwm_in = 1'b1; run(17, "R2", "R5");
        pwm_in = 1'b0; run(20, "R3", "R5");
    endtask

    task automatic t_short();
        cfg(15, 15, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            pwm_in = 1'b1; run(15, "R4", "R5");
            pwm_in = 1'b0; run(20, "R4", "R5");
        end
        pwm_in = 1'b1; run(16, "R4", "R5");
        pwm_in = 1'b0; run(20, "R4", "R5");
    endtask

    task automatic t_asym();
        cfg(3, 200, 1'b1, 1'b1);
        for (int k = 1; k < 8; k++) begin
            pwm_in = 1'b1; run(k, "R6", "R6");
            pwm_in = 1'b0; run(k * 40, "R6", "R6");
        end
        cfg(16383, 1, 1'b1, 1'b1);
        pwm_in = 1'b0; run(5, "R6", "R6");
        pwm_in = 1'b1; run(16400, "R6", "R6");
        pwm_in = 1'b0; run(10, "R6", "R6");
    endtask

    task automatic t_zero();
        cfg(0, 0, 1'b1, 1'b1);
        for (int k = 0; k < 40; k++) begin
            pwm_in = (k % 3 == 0) || (k % 7 == 1);
            step("R7", "R7");
        end
        pwm_in = 1'b0; run(3, "R7", "R7");
    endtask

    task automatic t_bypass(logic ea, logic eb);
        cfg(15, 15, ea, eb);
        for (int w = 1; w < 10; w++) begin
            pwm_in = 1'b1; run(w, "R8", "R8");
            pwm_in = 1'b0; run(10 - w, "R8", "R8");
        end
        pwm_in = 1'b0; run(20, "R8", "R8");
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(1_500_000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_nominal();
        t_short();
        t_asym();
        t_zero();
        t_bypass(1'b0, 1'b0);
        t_bypass(1'b0, 1'b1);
        t_bypass(1'b1, 1'b0);
        finish_run();
    end

endmodule